// File: doc/BRIEF.md
# Integer Compare, Carry, Leading-Zero and Byte-Match Unit

This unit is an arithmetic helper for a 32-bit processor datapath. From two operands, a carry-in and a 3-bit operation code it computes one of five results: a signed or an unsigned compare word, the carry-out of an add-with-carry, the number of leading zero bits of an operand, or the index of the first equal byte lane between two operands. The chosen result is captured in an output register on any cycle where the input strobe is high, and an output strobe marks it valid one cycle later.

The compare word is the difference b minus a, with its top bit rewritten when the operand signs differ, so that bit 31 alone tells the ordering. The byte-match index counts lanes from 1 starting at the most significant byte. A two-state controller (ST_IDLE, ST_LOADED) tracks whether the output register holds a result captured in the previous cycle: ST_IDLE goes to ST_LOADED on a cycle with in_valid high (transition LOAD) and stays otherwise (transition WAIT); ST_LOADED stays on in_valid high (transition RELOAD) and returns to ST_IDLE otherwise (transition DRAIN).

Top module: `cmp_bmatch_unit`

## Requirements
- R1: After reset, out_valid is 0 and result is 0.
- R2: Op code 0 (signed compare) returns d = b + ~a + 1 modulo 2^32; when bit 31 of a and bit 31 of b differ, bit 31 of the result is replaced by bit 31 of b, bits 30:0 stay those of d.
- R3: Op code 1 (unsigned compare) returns the same difference d; when bit 31 of a and bit 31 of b differ, bit 31 of the result is replaced by bit 31 of a.
- R4: Op code 2 (carry) returns in bit 0 the carry-out of a + b + cin, and 0 in bits 31:1.
- R5: Op code 3 (leading zeros) returns the count of leading zero bits of a, from 0 to 32; an all-zero a returns 32. Operand b is ignored.
- R6: Op code 4 (byte match) compares the byte lanes of a and b, lane 1 being bits 31:24 and lane 4 bits 7:0, and returns the number of the first equal lane scanning from lane 1, or 0 when no lane is equal.
- R7: Op codes 5, 6 and 7 return 0.
- R8: The result register loads only on a cycle with in_valid high; out_valid is high in exactly the cycle after such a cycle; with in_valid low the result keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; loads the result register |
| op | input | 3 | Operation code |
| opa | input | 32 | Operand a |
| opb | input | 32 | Operand b |
| cin | input | 1 | Carry-in for op code 2 |
| out_valid | output | 1 | High the cycle after a load |
| result | output | 32 | Registered result |

## Verification
The hardest cases are the carry boundary where b is all ones with carry-in set, where a narrow b + cin wraps to zero, and the byte-match priority when several lanes are equal at once. The bench reaches the carry corner through an exhaustive cross of a small set of edge operands (zero, one, all ones, sign boundaries) with both carry-in values, and reaches the priority cases by sweeping all sixteen patterns of equal and unequal lanes. Compare words are checked over the same edge cross so that every sign combination of a and b appears.

// File: rtl/cmp_bmatch_pkg.sv
package cmp_bmatch_pkg;

    typedef enum logic [2:0] {
        OP_CMP_S  = 3'd0,
        OP_CMP_U  = 3'd1,
        OP_CARRY  = 3'd2,
        OP_LZC    = 3'd3,
        OP_BMATCH = 3'd4
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } state_e;

endpackage

// File: rtl/cmp_word_unit.sv
module cmp_word_unit #(
    parameter int DATA_W = 32
) (
    input  logic              is_unsigned,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] word
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] diff;
    logic              signs_differ;
    logic              top_bit;

    always_comb begin
        diff         = b + ~a + {{(DATA_W-1){1'b0}}, 1'b1};
        signs_differ = a[MSB] ^ b[MSB];
        top_bit      = is_unsigned ? a[MSB] : b[MSB];
        word         = diff;
        if (signs_differ) begin
            word[MSB] = top_bit;
        end
    end
endmodule

// File: rtl/carry_unit.sv
module carry_unit #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic              cout
);
    logic [DATA_W-1:0] headroom;
    logic [DATA_W-1:0] b_plus_c;
    logic              b_full;

    always_comb begin
        headroom = ~a;
        b_plus_c = b + {{(DATA_W-1){1'b0}}, cin};
        b_full   = &b;
        if (b_full && cin) begin
            cout = 1'b1;
        end else if (headroom < b_plus_c) begin
            cout = 1'b1;
        end else begin
            cout = 1'b0;
        end
    end
endmodule

// File: rtl/lzc_unit.sv
module lzc_unit #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] a,
    output logic [CNT_W-1:0]  count
);
    logic found;

    always_comb begin
        count = CNT_W'(DATA_W);
        found = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!found && a[i]) begin
                count = CNT_W'(DATA_W - 1 - i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bmatch_unit.sv
module bmatch_unit #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int IDX_W  = $clog2(LANES + 1)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [IDX_W-1:0]  index
);
    logic [LANES-1:0] lane_eq;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            localparam int HI = DATA_W - 1 - g * LANE_W;
            localparam int LO = HI - LANE_W + 1;
            assign lane_eq[g] = (a[HI:LO] == b[HI:LO]);
        end
    endgenerate

    logic hit;

    always_comb begin
        index = '0;
        hit   = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (!hit && lane_eq[i]) begin
                index = IDX_W'(i + 1);
                hit   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmp_bmatch_unit.sv
module cmp_bmatch_unit
    import cmp_bmatch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              cin,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam int IDX_W = $clog2(LANES + 1);

    logic [DATA_W-1:0] cmp_word;
    logic              carry_out;
    logic [CNT_W-1:0]  lz_count;
    logic [IDX_W-1:0]  match_idx;
    logic [DATA_W-1:0] next_result;
    logic              sel_unsigned;

    state_e state_q, state_d;

    assign sel_unsigned = (op == OP_CMP_U);

    cmp_word_unit #(.DATA_W(DATA_W)) u_cmp (
        .is_unsigned (sel_unsigned),
        .a           (opa),
        .b           (opb),
        .word        (cmp_word)
    );

    carry_unit #(.DATA_W(DATA_W)) u_carry (
        .a    (opa),
        .b    (opb),
        .cin  (cin),
        .cout (carry_out)
    );

    lzc_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lzc (
        .a     (opa),
        .count (lz_count)
    );

    bmatch_unit #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W)
    ) u_bm (
        .a     (opa),
        .b     (opb),
        .index (match_idx)
    );

    always_comb begin
        case (op)
            OP_CMP_S, OP_CMP_U: next_result = cmp_word;
            OP_CARRY:           next_result = {{(DATA_W-1){1'b0}}, carry_out};
            OP_LZC:             next_result = {{(DATA_W-CNT_W){1'b0}}, lz_count};
            OP_BMATCH:          next_result = {{(DATA_W-IDX_W){1'b0}}, match_idx};
            default:            next_result = '0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_LOADED : ST_IDLE;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= next_result;
        end
    end

    assign out_valid = (state_q == ST_LOADED);

endmodule

// File: rtl/cmp_bmatch_checker.sv
module cmp_bmatch_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    p_carry_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd2) |=> (result[DATA_W-1:1] == '0));

    p_lzc_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd3) |=> (result <= DATA_W));

    p_bmatch_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd4) |=> (result <= DATA_W / 8));

    p_undef_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 3'd4) |=> (result == '0));
endmodule

bind cmp_bmatch_unit cmp_bmatch_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_cmp_bmatch_unit.sv
`timescale 1ns/1ps
module tb_cmp_bmatch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        cin = 1'b0;
    logic        out_valid;
    logic [31:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_bmatch_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .cin(cin),
        .out_valid(out_valid), .result(result)
    );

    logic [31:0] edges [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                               32'h8000_0000, 32'h8000_0001, 32'hFFFF_FFFF,
                               32'hFFFF_FFFE, 32'h1234_5678};

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_cmp(logic [31:0] a, logic [31:0] b, bit uns);
        logic [31:0] d;
        d = b - a;
        if (a[31] != b[31]) d[31] = uns ? a[31] : b[31];
        return d;
    endfunction

    function automatic logic [31:0] m_carry(logic [31:0] a, logic [31:0] b, logic c);
        logic [32:0] s;
        s = {1'b0, a} + {1'b0, b} + {32'd0, c};
        return {31'd0, s[32]};
    endfunction

    function automatic logic [31:0] m_lzc(logic [31:0] a);
        int n;
        n = 0;
        while (n < 32 && a[31-n] == 1'b0) n++;
        return n;
    endfunction

    function automatic logic [31:0] m_bm(logic [31:0] a, logic [31:0] b);
        for (int k = 0; k < 4; k++)
            if (a[31-8*k -: 8] == b[31-8*k -: 8]) return k + 1;
        return 0;
    endfunction

    // Drive one operation, sample one cycle after the capturing edge.
    task automatic run(logic [2:0] o, logic [31:0] a, logic [31:0] b, logic c,
                       string req, logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; op = o; opa = a; opb = b; cin = c;
        @(posedge clk);
        #1;
        check({req, " out_valid"}, {31'd0, out_valid}, 32'd1);
        check(req, result, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2, R3, R4: exhaustive edge cross
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                run(3'd0, edges[i], edges[j], 1'b0, "R2", m_cmp(edges[i], edges[j], 1'b0));
                run(3'd1, edges[i], edges[j], 1'b0, "R3", m_cmp(edges[i], edges[j], 1'b1));
                run(3'd2, edges[i], edges[j], 1'b0, "R4", m_carry(edges[i], edges[j], 1'b0));
                run(3'd2, edges[i], edges[j], 1'b1, "R4", m_carry(edges[i], edges[j], 1'b1));
            end
        run(3'd2, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, "R4 b-full corner", 32'd1);
        run(3'd2, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, "R4 no-carry corner", 32'd0);

        // R5: every leading one position, with noise below and b varied
        run(3'd3, 32'd0, 32'hFFFF_FFFF, 1'b0, "R5 zero", 32'd32);
        for (int p = 0; p < 32; p++) begin
            logic [31:0] v;
            v = (32'd1 << p) | ((32'hA5A5_A5A5 >> (32 - p)) & ((32'd1 << p) - 1));
            if (p == 0) v = 32'd1;
            run(3'd3, v, $urandom, 1'b0, "R5", m_lzc(v));
        end

        // R6: all 16 lane-equality patterns
        for (int m = 0; m < 16; m++) begin
            logic [31:0] a, b;
            a = 32'h1122_3344;
            b = a;
            for (int k = 0; k < 4; k++)
                if (!m[3-k]) b[31-8*k -: 8] = ~a[31-8*k -: 8];
            run(3'd4, a, b, 1'b0, "R6", m_bm(a, b));
        end
        run(3'd4, 32'h0102_0304, 32'hF0F0_F0F0, 1'b0, "R6 none", 32'd0);
        run(3'd4, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, "R6 all", 32'd1);

        // R7: undefined op codes
        for (int o = 5; o < 8; o++)
            run(3'(o), 32'h0000_0001, 32'hFFFF_FFFF, 1'b1, "R7", 32'd0);

        // Random mix across all ops
        for (int n = 0; n < 200; n++) begin
            logic [31:0] a, b;
            logic [31:0] e;
            logic c;
            logic [2:0] o;
            a = $urandom; b = $urandom; c = 1'($urandom); o = 3'($urandom % 5);
            if (n % 3 == 0) b = {a[31:16], b[15:0]};
            case (o)
                3'd0: e = m_cmp(a, b, 1'b0);
                3'd1: e = m_cmp(a, b, 1'b1);
                3'd2: e = m_carry(a, b, c);
                3'd3: e = m_lzc(a >> (n % 32));
                default: e = m_bm(a, b);
            endcase
            if (o == 3'd3) a = a >> (n % 32);
            run(o, a, b, c, "R2 R3 R4 R5 R6 random", e);
        end

        // R8: hold with in_valid low, inputs changing
        run(3'd3, 32'h0000_0100, 32'd0, 1'b0, "R8 load", 32'd23);
        held = 32'd23;
        @(negedge clk);
        in_valid = 1'b0; op = 3'd0; opa = 32'h5; opb = 32'h9;
        @(posedge clk); #1;
        check("R8 out_valid low", {31'd0, out_valid}, 32'd0);
        check("R8 hold", result, held);
        @(negedge clk); op = 3'd4; opa = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        check("R8 hold2", result, held);
        run(3'd0, 32'd3, 32'd10, 1'b0, "R8 reload", 32'd7);
        @(negedge clk); in_valid = 1'b0;
        @(posedge clk); #1;
        check("R8 drop", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule